// File: doc/BRIEF.md
# Energy-Bin Pulse Classifier with Pseudo-Random Event Counters

This block is the digital back end of one photon-detection channel. Eight clocked comparators, each tied to its own energy threshold, feed it one bit apiece every clock cycle. When the lowest-threshold comparator trips, the block opens a measurement window of programmable length. During that window every comparator that fires is latched into its own sticky flag. When the window closes, the block increments exactly one of eight event counters: the one whose threshold is the highest seen during the window. It then raises a filter-reset output and holds off for a programmable dead time before it arms for the next pulse.

The counters are 8-bit maximal-length shift-register sequences, not binary counters. The carry chain is replaced by a single feedback XOR tree, and an external unit converts the sequence value back to an integer. Two sticky status bits report a counter that has wrapped and a comparator pattern that cannot come from a monotonic threshold ladder. A snapshot request copies every counter and both status bits into shadow registers and restarts the live counters in the same cycle, so no event is lost between frames.

Top module: `ebin_channel`

## Requirements
- R1: After reset every live counter holds 8'h01, both status bits are 0, all shadow counters and shadow status bits are 0, and the filter-reset output is low.
- R2: While idle, a sampled 1 on comparator bit 0 starts an event at that edge (T0). The decision edge is T0+n1, or T0+1 when n1 is 0. At the decision edge exactly one counter advances: the one at the index of the highest comparator bit sampled at 1 on any edge from T0 through the decision edge.
- R3: A counter advances from q to {q[6:0], q[7]^q[5]^q[4]^q[3]}, starting from 8'h01 after reset or snapshot, and it never holds 8'h00.
- R4: The filter-reset output goes high at the decision edge and goes low at edge T0+max(nfr, n1+1).
- R5: After a decision, no new event can start until n2 cycles have passed and the filter reset has been released. A comparator pulse in that window changes no counter.
- R6: Status bit 0 is set, and stays set until a snapshot, when a counter advances from its last state back to 8'h01.
- R7: Status bit 1 is set on any edge where the sampled comparator vector is not a thermometer code (zero or more ones from bit 0 upward, then zeros), whatever the block's state. It stays set until a snapshot.
- R8: On an edge with the snapshot request high, the shadow registers take the counter and status values from before that edge. The live counters return to 8'h01 and the status bits clear. An increment on the same edge is applied to the restarted count, and a bad comparator pattern on the same edge sets the restarted status bit 1.
- R9: While idle, comparator activity with bit 0 low starts no event and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock; comparators are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_i | input | NUM_BINS | Comparator outputs, bit 0 is the lowest threshold |
| n1_i | input | DLY_W | Measurement window length in cycles |
| n2_i | input | DLY_W | Dead time after the decision in cycles |
| nfr_i | input | DLY_W | Minimum cycles from event start to filter-reset release |
| snap_i | input | 1 | Snapshot request: copy to shadows and restart counting |
| filt_rst_o | output | 1 | Filter reset drive to the analog shaper |
| cnt_o | output | NUM_BINS*CNT_W | Live counters, bin i at bits [i*CNT_W +: CNT_W] |
| stat_o | output | 2 | Live status: bit 0 wrap, bit 1 bad comparator pattern |
| shot_cnt_o | output | NUM_BINS*CNT_W | Shadow counters from the last snapshot |
| shot_stat_o | output | 2 | Shadow status from the last snapshot |

## Verification
A counter is due one register after its decision edge, so the bench reads it at the falling edge after edge T0+n1 (or T0+1 when n1 is 0), and checks the n1 = 0 case on both sides of that edge. Filter reset is sampled at each falling edge after T0+k and compared with the window from n1 to max(nfr, n1+1). Status bits and shadow registers are due on the edge that samples the pattern or the request, and the bench reads them at the next falling edge. In random runs the bench leaves n1+n2+nfr+4 idle cycles after every event before it compares the full counter set, and it drives stimulus only at falling edges.

// File: rtl/ebin_pkg.sv
// Package: shared constants, state type and sequence step for the
// energy-bin classifier. Assumes 8-bit counters with a fixed tap set.
package ebin_pkg;

    localparam int          CNT_W    = 8;
    localparam logic [7:0]  CNT_SEED = 8'h01;
    // Taps 8,6,5,4 of x^8+x^6+x^5+x^4+1 map to bits 7,5,4,3.
    localparam logic [7:0]  CNT_TAPS = 8'hB8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_MEAS = 2'd1,
        SEQ_DEAD = 2'd2
    } seq_state_e;

    // Next state of the shift-register counter.
    function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] q);
        return {q[CNT_W-2:0], ^(q & CNT_TAPS)};
    endfunction

endpackage

// File: rtl/ebin_lfsr_ctr.sv
// One event counter built as a maximal-length shift register.
// Assumes clr_i has priority: a restart with inc_i lands on one step past SEED.
// wrap_o flags an advance from the final state back to SEED.
module ebin_lfsr_ctr
    import ebin_pkg::*;
#(
    parameter logic [CNT_W-1:0] SEED = CNT_SEED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] q_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] q;
    logic [CNT_W-1:0] q_adv;

    // Purpose: one feedback step of the current value.
    always_comb q_adv = cnt_step(q);

    // Purpose: restart, advance or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (clr_i) begin
            q <= inc_i ? cnt_step(SEED) : SEED;
        end else if (inc_i) begin
            q <= q_adv;
        end
    end

    // Purpose: flag a wrap that is not masked by a restart.
    always_comb wrap_o = inc_i && !clr_i && (q_adv == SEED);

    assign q_o = q;

endmodule

// File: rtl/ebin_peak_hold.sv
// Digital peak hold: sticky flag per comparator, priority pick of the
// highest flag, and a thermometer-code check of the raw comparator word.
// Assumes bit 0 is the lowest threshold and capture/clear come from the sequencer.
module ebin_peak_hold #(
    parameter int NUM_BINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BINS-1:0] cmp_i,
    input  logic                capture_i,
    input  logic                clear_i,
    output logic [NUM_BINS-1:0] top_oh_o,
    output logic                bad_o
);

    logic [NUM_BINS-1:0] hold;
    logic [NUM_BINS-1:0] merged;

    // Purpose: accumulate comparator hits while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (clear_i) begin
            hold <= '0;
        end else if (capture_i) begin
            hold <= hold | cmp_i;
        end
    end

    // Purpose: include the current sample so the decision edge counts too.
    always_comb merged = hold | cmp_i;

    // Purpose: one-hot mark of the highest set flag.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_BINS; gi++) begin : g_pick
            if (gi == NUM_BINS - 1) begin : g_top
                assign top_oh_o[gi] = merged[gi];
            end else begin : g_low
                assign top_oh_o[gi] = merged[gi] & ~(|merged[NUM_BINS-1:gi+1]);
            end
        end
    endgenerate

    // Purpose: a thermometer word plus one has no bit in common with itself.
    always_comb bad_o = |(cmp_i & (cmp_i + 1'b1));

endmodule

// File: rtl/ebin_seq.sv
// Event sequencer: idle -> measuring (n1 cycles) -> dead (n2 cycles and
// filter reset released). Drives capture, decision and filter reset.
// Assumes n1 of 0 behaves as 1; age saturates so long programs stay safe.
module ebin_seq
    import ebin_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [DLY_W-1:0] n1_i,
    input  logic [DLY_W-1:0] n2_i,
    input  logic [DLY_W-1:0] nfr_i,
    output logic             capture_o,
    output logic             decide_o,
    output logic             filt_rst_o
);

    localparam int AGE_W = DLY_W + 1;

    seq_state_e       st;
    logic [DLY_W-1:0] win_tmr;
    logic [DLY_W-1:0] dead_tmr;
    logic [AGE_W-1:0] age;
    logic [AGE_W-1:0] age_inc;
    logic             frst;

    // Purpose: saturating age since the event started.
    always_comb age_inc = (&age) ? age : age + 1'b1;

    // Purpose: state, window, dead-time and filter-reset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SEQ_IDLE;
            win_tmr  <= '0;
            dead_tmr <= '0;
            age      <= '0;
            frst     <= 1'b0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (trig_i) begin
                        st      <= SEQ_MEAS;
                        win_tmr <= (n1_i == '0) ? DLY_W'(1) : n1_i;
                        age     <= '0;
                    end
                end
                SEQ_MEAS: begin
                    age <= age_inc;
                    if (win_tmr == DLY_W'(1)) begin
                        st       <= SEQ_DEAD;
                        dead_tmr <= n2_i;
                        frst     <= 1'b1;
                    end else begin
                        win_tmr <= win_tmr - 1'b1;
                    end
                end
                SEQ_DEAD: begin
                    age <= age_inc;
                    if (dead_tmr != '0) begin
                        dead_tmr <= dead_tmr - 1'b1;
                    end
                    if (frst && (age_inc >= AGE_W'(nfr_i))) begin
                        frst <= 1'b0;
                    end
                    if ((dead_tmr == '0) && !frst) begin
                        st <= SEQ_IDLE;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    // Purpose: open the sticky flags on the trigger edge and through the window.
    always_comb capture_o = ((st == SEQ_IDLE) && trig_i) || (st == SEQ_MEAS);

    // Purpose: the decision falls on the last window edge.
    always_comb decide_o = (st == SEQ_MEAS) && (win_tmr == DLY_W'(1));

    assign filt_rst_o = frst;

endmodule

// File: rtl/ebin_channel.sv
// Top of one channel: peak hold, sequencer, one counter per bin, sticky
// status and snapshot shadows. Assumes comparator bits are already
// synchronous to clk.
module ebin_channel
    import ebin_pkg::*;
#(
    parameter int NUM_BINS = 8,
    parameter int DLY_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BINS-1:0]       cmp_i,
    input  logic [DLY_W-1:0]          n1_i,
    input  logic [DLY_W-1:0]          n2_i,
    input  logic [DLY_W-1:0]          nfr_i,
    input  logic                      snap_i,
    output logic                      filt_rst_o,
    output logic [NUM_BINS*CNT_W-1:0] cnt_o,
    output logic [1:0]                stat_o,
    output logic [NUM_BINS*CNT_W-1:0] shot_cnt_o,
    output logic [1:0]                shot_stat_o
);

    localparam int VEC_W = NUM_BINS * CNT_W;

    logic                capture;
    logic                decide;
    logic                bad_pat;
    logic [NUM_BINS-1:0] top_oh;
    logic [NUM_BINS-1:0] inc_vec;
    logic [NUM_BINS-1:0] wrap_vec;
    logic [1:0]          stat;
    logic [VEC_W-1:0]    shot_cnt;
    logic [1:0]          shot_stat;

    ebin_peak_hold #(
        .NUM_BINS (NUM_BINS)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_i     (cmp_i),
        .capture_i (capture),
        .clear_i   (decide),
        .top_oh_o  (top_oh),
        .bad_o     (bad_pat)
    );

    ebin_seq #(
        .DLY_W (DLY_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (cmp_i[0]),
        .n1_i       (n1_i),
        .n2_i       (n2_i),
        .nfr_i      (nfr_i),
        .capture_o  (capture),
        .decide_o   (decide),
        .filt_rst_o (filt_rst_o)
    );

    // Purpose: route the decision to the chosen bin only.
    always_comb inc_vec = decide ? top_oh : '0;

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BINS; gb++) begin : g_bin
            ebin_lfsr_ctr #(
                .SEED (CNT_SEED)
            ) u_ctr (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr_i  (snap_i),
                .inc_i  (inc_vec[gb]),
                .q_o    (cnt_o[gb*CNT_W +: CNT_W]),
                .wrap_o (wrap_vec[gb])
            );
        end
    endgenerate

    // Purpose: sticky status, restarted by a snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else if (snap_i) begin
            stat <= {bad_pat, 1'b0};
        end else begin
            stat <= stat | {bad_pat, |wrap_vec};
        end
    end

    // Purpose: capture counters and status into the shadows on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shot_cnt  <= '0;
            shot_stat <= '0;
        end else if (snap_i) begin
            shot_cnt  <= cnt_o;
            shot_stat <= stat;
        end
    end

    assign stat_o      = stat;
    assign shot_cnt_o  = shot_cnt;
    assign shot_stat_o = shot_stat;

endmodule

// File: rtl/ebin_channel_chk.sv
// Checker for ebin_channel, attached by bind below.
module ebin_channel_chk #(
    parameter int NUM_BINS = 8,
    parameter int CNT_W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_BINS-1:0]       cmp_i,
    input logic                      snap_i,
    input logic                      filt_rst_o,
    input logic [NUM_BINS*CNT_W-1:0] cnt_o,
    input logic [1:0]                stat_o,
    input logic [1:0]                shot_stat_o,
    input logic [NUM_BINS-1:0]       inc_vec
);

    AST_SINGLE_BIN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc_vec)); // R2

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_rst_o && !snap_i) |=> $stable(cnt_o)); // R5

    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[0] && !snap_i) |=> stat_o[0]); // R6

    AST_BAD_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_i & (cmp_i + 1'b1)) != '0) |=> stat_o[1]); // R7

    AST_SHADOW_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> (shot_stat_o == $past(stat_o))); // R8

    genvar gc;
    generate
        for (gc = 0; gc < NUM_BINS; gc++) begin : g_nz
            AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_o[gc*CNT_W +: CNT_W] != '0); // R3
        end
    endgenerate

endmodule

bind ebin_channel ebin_channel_chk #(
    .NUM_BINS (NUM_BINS),
    .CNT_W    (ebin_pkg::CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_i       (cmp_i),
    .snap_i      (snap_i),
    .filt_rst_o  (filt_rst_o),
    .cnt_o       (cnt_o),
    .stat_o      (stat_o),
    .shot_stat_o (shot_stat_o),
    .inc_vec     (inc_vec)
);

// File: tb/ebin_channel_test.sv
module ebin_channel_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 8;
    localparam int DW         = 8;
    localparam int MAX_CYC    = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] cmp = '0;
    logic [DW-1:0] n1 = '0, n2 = '0, nfr = '0;
    logic          snap = 1'b0;
    logic          filt_rst;
    logic [NB*8-1:0] cnt, shot_cnt;
    logic [1:0]    stat, shot_stat;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0]    exp_q [NB];
    logic [1:0]    exp_stat = '0;
    logic [NB*8-1:0] exp_shot = '0;
    logic [1:0]    exp_shot_stat = '0;

    ebin_channel uut (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .n1_i(n1), .n2_i(n2),
        .nfr_i(nfr), .snap_i(snap), .filt_rst_o(filt_rst), .cnt_o(cnt),
        .stat_o(stat), .shot_cnt_o(shot_cnt), .shot_stat_o(shot_stat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] nx(input logic [7:0] q);
        return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
    endfunction

    function automatic logic [7:0] therm(input int n);
        return 8'((9'd1 << n) - 1);
    endfunction

    function automatic bit is_therm(input logic [7:0] v);
        for (int i = 0; i < 9; i++) if (v == therm(i)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int top_bit(input logic [7:0] v);
        int t = -1;
        for (int i = 0; i < NB; i++) if (v[i]) t = i;
        return t;
    endfunction

    function automatic logic [NB*8-1:0] exp_vec();
        logic [NB*8-1:0] v;
        for (int i = 0; i < NB; i++) v[i*8 +: 8] = exp_q[i];
        return v;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > MAX_CYC) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, MAX_CYC);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, 128'(cnt), 128'(exp_vec()));
        chk(req, 128'(stat), 128'(exp_stat));
    endtask

    // Model one decision on bin b.
    task automatic model_inc(input int b);
        exp_q[b] = nx(exp_q[b]);
        if (exp_q[b] == 8'h01) exp_stat[0] = 1'b1;
    endtask

    task automatic model_snap();
        exp_shot      = exp_vec();
        exp_shot_stat = exp_stat;
        for (int i = 0; i < NB; i++) exp_q[i] = 8'h01;
        exp_stat = '0;
    endtask

    // One event: p1 on the trigger edge, p2 on the next, then quiet.
    task automatic run_event(input logic [7:0] p1, input logic [7:0] p2);
        logic [7:0] a = p1 | 8'h01;
        @(negedge clk); cmp = a;
        @(negedge clk); cmp = p2;
        @(negedge clk); cmp = '0;
        if (!is_therm(a) || !is_therm(p2)) exp_stat[1] = 1'b1;
        model_inc(top_bit(a | p2));
        repeat (int'(n1) + int'(n2) + int'(nfr) + 4) @(negedge clk);
    endtask

    task automatic do_snap();
        @(negedge clk); snap = 1'b1;
        @(negedge clk); snap = 1'b0;
        model_snap();
        chk("R8 shadow counters", 128'(shot_cnt), 128'(exp_shot));
        chk("R8 shadow status", 128'(shot_stat), 128'(exp_shot_stat));
        chk_state("R8 restarted counters");
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NB; i++) exp_q[i] = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_state("R1 reset live");
        chk("R1 reset shadow", 128'(shot_cnt), 128'(0));
        chk("R1 reset shadow status", 128'(shot_stat), 128'(0));
        chk("R1 reset filter", 128'(filt_rst), 128'(0));

        // R4 filter-reset window, nfr beyond the window
        n1 = 3; n2 = 0; nfr = 6;
        @(negedge clk); cmp = 8'h01;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk); cmp = '0;
            chk($sformatf("R4 filter k=%0d", k), 128'(filt_rst), 128'((k >= 3) && (k < 6)));
        end
        model_inc(0);
        chk_state("R2 bin0 after filter test");

        // R4 window longer than nfr
        n1 = 8; nfr = 2;
        @(negedge clk); cmp = 8'h03;
        for (int k = 0; k < 11; k++) begin
            @(negedge clk); cmp = '0;
            chk($sformatf("R4 filter long k=%0d", k), 128'(filt_rst), 128'(k == 8));
        end
        model_inc(1);
        chk_state("R2 bin1 after long window");

        // R2 n1 of zero behaves as one
        n1 = 0; n2 = 0; nfr = 0;
        @(negedge clk); cmp = therm(5);
        @(negedge clk); cmp = '0;
        chk_state("R2 n1=0 no change at T0");
        model_inc(4);
        @(negedge clk);
        chk_state("R2 n1=0 change at T0+1");
        repeat (4) @(negedge clk);

        // R5 pulse in dead time ignored
        n1 = 2; n2 = 10; nfr = 0;
        @(negedge clk); cmp = 8'h01;
        @(negedge clk); cmp = '0;
        repeat (4) @(negedge clk);
        cmp = 8'hFF;
        @(negedge clk); cmp = '0;
        model_inc(0);
        repeat (16) @(negedge clk);
        chk_state("R5 dead-time pulse ignored");

        // R9 idle activity without bit 0
        n2 = 0;
        @(negedge clk); cmp = 8'h04;
        @(negedge clk); cmp = '0;
        exp_stat[1] = 1'b1;
        repeat (6) @(negedge clk);
        chk_state("R9 no trigger without bit0, R7 flagged");
        do_snap();

        // R8 snapshot on the decision edge
        n1 = 2; n2 = 0; nfr = 0;
        run_event(therm(2), 8'h00);
        @(negedge clk); cmp = therm(3);
        @(negedge clk); cmp = '0;
        @(negedge clk); snap = 1'b1;
        @(negedge clk); snap = 1'b0;
        model_snap();
        exp_q[2] = nx(8'h01);
        chk("R8 same-edge shadow", 128'(shot_cnt), 128'(exp_shot));
        chk_state("R8 increment lands on restarted count");
        repeat (4) @(negedge clk);

        // R3 sequence and R6 wrap on bin 7
        do_snap();
        n1 = 1; n2 = 0; nfr = 0;
        for (int e = 0; e < 254; e++) run_event(8'hFF, 8'h00);
        chk_state("R3 sequence after 254 steps, R6 not yet");
        run_event(8'hFF, 8'h00);
        chk("R6 wrap back to seed", 128'(cnt[63:56]), 128'(8'h01));
        chk_state("R6 wrap flagged");
        do_snap();

        // Random events
        for (int e = 0; e < 80; e++) begin
            logic [7:0] p1, p2;
            n1  = DW'($urandom_range(1, 6));
            n2  = DW'($urandom_range(0, 5));
            nfr = DW'($urandom_range(0, 8));
            p1 = therm($urandom_range(1, 8));
            p2 = ($urandom_range(0, 2) == 0) ? therm($urandom_range(0, 8)) : 8'h00;
            if ($urandom_range(0, 7) == 0) p2 = p2 | 8'(1 << $urandom_range(1, 7));
            run_event(p1, p2);
            chk_state($sformatf("R2 R3 R7 random event %0d", e));
            if ($urandom_range(0, 5) == 0) do_snap();
        end

        finish_run();
    end

endmodule